// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Control

This block is a single-lane SPI master that software drives through a small 32-bit register bus. Four word registers sit at fixed offsets: a control word with a ready flag and per-slave select enables, a configuration word with clock shape and divider, a transmit word and a receive word. Writing the transmit word is the whole trigger. The block shifts its low byte out, most significant bit first, and at the same time collects a byte from the slave. The collected byte then appears in the receive word.

Software polls the ready flag before each access. The select lines are plain register bits, so the caller frames multi-byte transactions itself by asserting a select, pushing bytes, and releasing it. Each configuration write can also carry a flush command. The flush aborts any byte in flight and clears its bit again without help from software.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset the control word reads 0x0000_0002 (ready set, no select enabled), the configuration and receive words read 0, every select output is high and the serial clock is low.
- R2: The control word is at offset 0x0, configuration at 0x4, transmit at 0x8 and receive at 0xC. Configuration bits 4:0 are the prescaler, bit 6 the clock phase and bit 7 the clock polarity, and these read back as written.
- R3: Control bit 16+n enables slave n, and select output n is driven low while that bit is 1. Select outputs do not change while a byte is shifting.
- R4: A write to offset 0x8 while ready (control bit 1) is 1 starts a transfer, and ready reads 0 in the cycle after the write. Ready returns to 1 once the byte is complete, and the receive word then holds the byte from the slave in bits 7:0 with zeros above.
- R5: Both data lines carry the most significant bit first in all four modes. The clock idles at the polarity bit. With phase 0 the slave data is sampled on the leading clock edge and the output changes on the trailing edge. With phase 1 the output changes on the leading edge and sampling happens on the trailing edge.
- R6: Every serial clock half period lasts floor(P/2) input clock cycles for prescaler P of 2 or more. P of 0 or 1 behaves as 2, giving one cycle per half period.
- R7: One transfer produces exactly 16 serial clock edges, and the clock is back at its idle level when ready rises.
- R8: A write to the transmit word while ready is 0 has no effect on the byte in flight or on what follows.
- R9: Writing configuration bit 9 as 1 flushes the block. The bit reads 1 for one cycle and then 0. Any byte in flight is aborted, ready reads 1, the receive word reads 0 and the clock returns to idle.
- R10: Control bit 1 is read-only. Writing the control word never changes the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data towards the slaves |
| spi_miso | input | 1 | Serial data from the selected slave |
| spi_cs_n | output | NCS | Slave selects, active low |

## Verification
The checks inside the design assume that software keeps its side of the polling contract. The configuration word is rewritten only while ready is 1, because a change of polarity or phase in mid-byte would break the edge accounting. At most one register access occurs per cycle. The stimulus writes configuration and select bits only between transfers and always waits for ready before the next transmit write. It breaks that rule on purpose in two places only. One is the ignored transmit write during a busy byte. The other is a flush issued in mid-byte, and that flush carries the same clock fields as before.

// File: rtl/spi_leg_pkg.sv
`timescale 1ns/1ps
package spi_leg_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int EDGE_W = $clog2(2 * BYTE_W);

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_TX   = 4'h8;
    localparam logic [3:0] OFS_RX   = 4'hC;

    localparam int RDY_BIT   = 1;
    localparam int SEL_LSB   = 16;
    localparam int PHA_BIT   = 6;
    localparam int POL_BIT   = 7;
    localparam int FLUSH_BIT = 9;

    typedef struct packed {
        logic             pol;
        logic             pha;
        logic [PRE_W-1:0] pre;
    } clk_cfg_t;

    typedef enum logic { SH_IDLE = 1'b0, SH_BUSY = 1'b1 } sh_state_e;

    function automatic logic [PRE_W-1:0] half_period(input logic [PRE_W-1:0] pre);
        if (pre < PRE_W'(2))
            return PRE_W'(1);
        return pre >> 1;
    endfunction

endpackage

// File: rtl/spi_leg_regs.sv
`timescale 1ns/1ps
module spi_leg_regs
    import spi_leg_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                ready,
    input  logic [BYTE_W-1:0]   rx_byte,
    output clk_cfg_t            cfg,
    output logic [NCS-1:0]      sel_en,
    output logic                start,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                flush
);

    logic wr_ctrl, wr_cfg, wr_tx;
    logic unused_wdata;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == OFS_CFG);
    assign wr_tx   = bus_sel && bus_wr && (bus_addr == OFS_TX);
    assign start   = wr_tx && ready;
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            sel_en  <= '0;
            tx_byte <= '0;
            flush   <= 1'b0;
        end else begin
            flush <= 1'b0;
            if (wr_ctrl)
                sel_en <= bus_wdata[SEL_LSB +: NCS];
            if (wr_cfg) begin
                cfg.pre <= bus_wdata[PRE_W-1:0];
                cfg.pha <= bus_wdata[PHA_BIT];
                cfg.pol <= bus_wdata[POL_BIT];
                flush   <= bus_wdata[FLUSH_BIT];
            end
            if (start)
                tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[RDY_BIT]          = ready;
                bus_rdata[SEL_LSB +: NCS]   = sel_en;
            end
            OFS_CFG: begin
                bus_rdata[PRE_W-1:0] = cfg.pre;
                bus_rdata[PHA_BIT]   = cfg.pha;
                bus_rdata[POL_BIT]   = cfg.pol;
                bus_rdata[FLUSH_BIT] = flush;
            end
            OFS_TX:  bus_rdata[BYTE_W-1:0] = tx_byte;
            OFS_RX:  bus_rdata[BYTE_W-1:0] = rx_byte;
            default: bus_rdata = '0;
        endcase
    end

    // R9: the flush command lives for a single cycle
    p_flush_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    // R8: a transmit write during a busy byte leaves the held byte alone
    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && !ready) |=> $stable(tx_byte));

endmodule

// File: rtl/spi_leg_clkdiv.sv
`timescale 1ns/1ps
module spi_leg_clkdiv
    import spi_leg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] half,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == half - PRE_W'(1));
    assign tick = run && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + PRE_W'(1);
    end

    // R6: the counter never passes the half period it divides by
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half));

endmodule

// File: rtl/spi_leg_shift.sv
`timescale 1ns/1ps
module spi_leg_shift
    import spi_leg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              flush,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              pha,
    input  logic              pol,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

    sh_state_e         state;
    logic [EDGE_W-1:0] edge_cnt;
    logic              phase;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;
    logic              leading, sample_now, shift_now;

    assign busy       = (state == SH_BUSY);
    assign leading    = !edge_cnt[0];
    assign sample_now = leading ^ pha;
    assign shift_now  = !sample_now && (edge_cnt != '0);
    assign sclk       = pol ^ phase;
    assign mosi       = tx_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state    <= SH_IDLE;
            edge_cnt <= '0;
            phase    <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rx_byte  <= '0;
        end else if (state == SH_IDLE) begin
            if (start) begin
                state    <= SH_BUSY;
                tx_sr    <= tx_byte;
                edge_cnt <= '0;
                phase    <= 1'b0;
            end
        end else if (tick) begin
            phase    <= !phase;
            edge_cnt <= edge_cnt + EDGE_W'(1);
            if (sample_now)
                rx_sr <= {rx_sr[BYTE_W-2:0], miso};
            if (shift_now)
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            if (edge_cnt == LAST_EDGE) begin
                state   <= SH_IDLE;
                rx_byte <= sample_now ? {rx_sr[BYTE_W-2:0], miso} : rx_sr;
            end
        end
    end

    // R7: an idle shifter has consumed all of its edges and parks the clock
    p_idle_parked_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (edge_cnt == '0 && sclk == pol));

    // R4: a byte always starts from edge zero
    p_start_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !flush) |=> (busy && edge_cnt == '0));

endmodule

// File: rtl/spi_legacy_master.sv
`timescale 1ns/1ps
module spi_legacy_master
    import spi_leg_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [3:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);

    clk_cfg_t          cfg;
    logic [NCS-1:0]    sel_en;
    logic              start, flush, busy, tick, ready;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    assign ready    = !busy;
    assign spi_cs_n = ~sel_en;

    spi_leg_regs #(.NCS(NCS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ready    (ready),
        .rx_byte  (rx_byte),
        .cfg      (cfg),
        .sel_en   (sel_en),
        .start    (start),
        .tx_byte  (tx_byte),
        .flush    (flush)
    );

    spi_leg_clkdiv u_div (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .half(half_period(cfg.pre)),
        .tick(tick)
    );

    spi_leg_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .flush  (flush),
        .tick   (tick),
        .tx_byte(bus_wdata[BYTE_W-1:0]),
        .pha    (cfg.pha),
        .pol    (cfg.pol),
        .miso   (spi_miso),
        .busy   (busy),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .rx_byte(rx_byte)
    );

    // R4: an accepted transmit write drops ready on the next cycle
    p_ready_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFS_TX && ready && !flush) |=> !ready);

    // R3: selects hold while shifting unless software rewrites control
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !(bus_sel && bus_wr && bus_addr == OFS_CTRL)) |=> $stable(spi_cs_n));

    // R10: a control write alone never moves the ready flag
    p_ready_ro_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && bus_sel && bus_wr && bus_addr == OFS_CTRL) |=> ready);

endmodule

// File: tb/test_spi_legacy_master.sv
`timescale 1ns/1ps
module test_spi_legacy_master;

    localparam int NCS = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           spi_sclk, spi_mosi;
    logic           spi_miso = 1'b0;
    logic [NCS-1:0] spi_cs_n;

    spi_legacy_master #(.NCS(NCS)) i_spi_legacy_master (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // slave model, evaluated between edges
    bit       slv_on = 0;
    bit       s_pol, s_pha, lead, have_last;
    logic [7:0] stx, srx;
    int       lead_cnt, trail_cnt, nedge, cyc, last_cyc, gmin, gmax, g;
    logic     sclk_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (slv_on && spi_sclk !== sclk_prev) begin
            lead = (spi_sclk != s_pol);
            if (have_last) begin
                g = cyc - last_cyc;
                if (g < gmin) gmin = g;
                if (g > gmax) gmax = g;
            end
            have_last = 1;
            last_cyc  = cyc;
            nedge++;
            if (lead) begin
                if (!s_pha) srx = {srx[6:0], spi_mosi};
                else if (lead_cnt < 8) spi_miso = stx[7-lead_cnt];
                lead_cnt++;
            end else begin
                if (s_pha) srx = {srx[6:0], spi_mosi};
                else if (trail_cnt < 7) spi_miso = stx[6-trail_cnt];
                trail_cnt++;
            end
        end
        sclk_prev = spi_sclk;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_ready(input string req);
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            rd(4'h0, v);
            if (v[1]) return;
            @(negedge clk);
        end
        chk(req, 32'hDEAD, 32'h2);
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input bit pol,
                        input bit pha, input logic [4:0] pre, input logic [3:0] sel,
                        input bit poke);
        logic [31:0] v;
        int h;
        h = (pre < 2) ? 1 : pre / 2;
        wr(4'h0, {12'h0, sel, 16'h0});
        wr(4'h4, {24'h0, pol, pha, 1'b0, pre});
        s_pol = pol; s_pha = pha; stx = sb; srx = 8'h00;
        lead_cnt = 0; trail_cnt = 0; nedge = 0; have_last = 0;
        gmin = 1000; gmax = 0;
        spi_miso = pha ? 1'b0 : sb[7];
        sclk_prev = spi_sclk;
        chk("R7 idle level before byte", {31'h0, spi_sclk}, {31'h0, pol});
        slv_on = 1;
        wr(4'h8, {24'h0, tx});
        rd(4'h0, v);
        chk("R4 ready drops", {31'h0, v[1]}, 32'h0);
        if (poke) wr(4'h8, {24'h0, ~tx});
        wait_ready("R4 ready returns");
        @(negedge clk);
        slv_on = 0;
        rd(4'hC, v);
        chk("R4 R5 received byte", v, {24'h0, sb});
        chk(poke ? "R8 R5 slave saw first byte" : "R5 slave saw byte", {24'h0, srx}, {24'h0, tx});
        chk("R7 edge count", nedge, 16);
        chk("R6 min half period", gmin, h);
        chk("R6 max half period", gmax, h);
        chk("R7 idle after byte", {31'h0, spi_sclk}, {31'h0, pol});
        chk("R3 selects", {28'h0, spi_cs_n}, {28'h0, ~sel});
        if (poke) begin
            rd(4'h0, v);
            chk("R8 no second byte", {31'h0, v[1]}, 32'h1);
        end
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        rd(4'h0, v); chk("R1 control after reset", v, 32'h0000_0002);
        rd(4'h4, v); chk("R1 config after reset", v, 32'h0);
        rd(4'hC, v); chk("R1 receive after reset", v, 32'h0);
        chk("R1 selects high", {28'h0, spi_cs_n}, 32'hF);
        chk("R1 clock low", {31'h0, spi_sclk}, 32'h0);

        // R10: writing 0 to the ready bit does not clear it
        wr(4'h0, 32'h0005_0000);
        rd(4'h0, v); chk("R10 R2 control readback", v, 32'h0005_0002);
        chk("R3 select decode", {28'h0, spi_cs_n}, 32'hA);
        wr(4'h4, 32'h0000_00C5);
        rd(4'h4, v); chk("R2 config readback", v, 32'h0000_00C5);

        // directed corners: all four modes, extreme prescalers
        xfer(8'hA5, 8'h3C, 0, 0, 5'd0, 4'h1, 0);
        xfer(8'h81, 8'h7E, 0, 1, 5'd1, 4'h2, 0);
        xfer(8'h00, 8'hFF, 1, 0, 5'd3, 4'h4, 1);
        xfer(8'hFF, 8'h01, 1, 1, 5'd31, 4'h8, 0);
        xfer(8'h5A, 8'h80, 0, 0, 5'd2, 4'h0, 1);

        for (int i = 0; i < 40; i++) begin
            xfer($urandom_range(0, 255), $urandom_range(0, 255), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                 4'($urandom_range(0, 15)), (i % 5) == 0);
        end

        // R9: flush in the middle of a byte
        wr(4'h4, 32'h0000_0014);
        slv_on = 0;
        wr(4'h8, 32'h0000_00C3);
        repeat (25) @(negedge clk);
        wr(4'h4, 32'h0000_0214);
        rd(4'h4, v); chk("R9 flush bit set", {31'h0, v[9]}, 32'h1);
        @(negedge clk);
        rd(4'h4, v); chk("R9 flush bit cleared", v, 32'h0000_0014);
        rd(4'h0, v); chk("R9 ready after flush", {31'h0, v[1]}, 32'h1);
        rd(4'hC, v); chk("R9 receive cleared", v, 32'h0);
        chk("R9 clock idle", {31'h0, spi_sclk}, 32'h0);
        xfer(8'h96, 8'h69, 0, 1, 5'd4, 4'h3, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule